// File: doc/BRIEF.md
# Serial Port Byte Queue with Fill-Level Interrupt

This block is a sixteen-slot first-in first-out byte queue for one direction of an asynchronous serial port. One side (software for transmit, the serial engine for receive) writes bytes in with a push strobe. The other side takes them out with a pop strobe. A live fill count goes from 0 to 16. The queue can be switched off, and it can be held empty by a run control.

An interrupt flag is raised by comparing the fill count with a programmable five-bit level. A parameter picks the direction. On the receive side the flag rises when the count has reached or passed the level. On the transmit side it rises when the count has drained to or below the level. The level resets to all ones, so an empty receive queue stays quiet after reset. The flag is sticky and is cleared by a write-one strobe. It comes back one clock later if the compare still holds. A sticky overflow flag records a byte lost to a full queue.

Top module: `serfifo_lvl`

## Requirements
- R1: After the synchronous reset `rst`, fill_count is 0, level is 5'b11111, pop_data is 0, and irq_flag, irq and ovf_flag are all 0.
- R2: Bytes leave in the order they were pushed. pop_data shows the popped byte from the clock edge that follows the pop strobe.
- R3: An accepted push adds one to fill_count and an accepted pop subtracts one. A push and a pop in the same cycle leave the count unchanged. The count never exceeds 16.
- R4: A push into a full queue without a pop in the same cycle discards the byte, leaves the count at 16 and sets ovf_flag. With a simultaneous pop, the push is accepted and no overflow is recorded.
- R5: ovf_flag stays set until an ovf_clr strobe clears it. An overflow event in the same cycle as the strobe wins.
- R6: A pop from an empty queue leaves pop_data at its last value and fill_count at 0.
- R7: While fifo_run is 0 the queue is held empty (fill_count 0) and push and pop are ignored. The level register keeps its value.
- R8: While fifo_en is 0, push and pop have no effect: the count and pop_data are held and the stored bytes are kept.
- R9: In receive mode (DIR = DIR_RX), irq_flag is set on the edge after a cycle in which fill_count >= level and no clear strobe is present.
- R10: In transmit mode (DIR = DIR_TX), irq_flag is set on the edge after a cycle in which fill_count <= level and no clear strobe is present.
- R11: An irq_clr strobe clears irq_flag on the next edge. The flag is set again one edge later if the compare still holds. Without a strobe the flag stays set.
- R12: The irq output is irq_flag gated by irq_en.
- R13: level_wr loads level_in into the level register. A level above 16 can never be met by the receive compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_run | input | 1 | 0 holds the queue empty with pointers cleared; 1 releases it |
| fifo_en | input | 1 | Queue enable; 0 makes push and pop ineffective |
| push | input | 1 | Write strobe |
| push_data | input | 8 | Byte to write |
| pop | input | 1 | Read strobe |
| pop_data | output | 8 | Last byte read |
| fill_count | output | 5 | Number of stored bytes, 0 to 16 |
| level_wr | input | 1 | Load strobe for the interrupt level |
| level_in | input | 5 | New interrupt level |
| level | output | 5 | Current interrupt level |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one clear for irq_flag |
| irq_flag | output | 1 | Sticky level-compare flag |
| irq | output | 1 | Interrupt request |
| ovf_clr | input | 1 | Write-one clear for ovf_flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The compare is swept over every level from 0 to 16 against every fill count from 0 to 16. A receive instance and a transmit instance run side by side on the same stimulus, which separates the >= compare from the <= compare at the equality point and at both ends. A full fill with a distinct byte pattern, followed by a full drain, shows that order is kept and that the count steps correctly. Pushing into a full queue, popping from an empty one and pushing and popping together are each checked on their own. This separates a discarded byte from a byte swapped in during a pop, and a stale read from a fresh one. Toggling enable and run with strobes present shows which state each control freezes and which it clears.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } fifo_dir_e;

    // Decoded operation for one cycle
    typedef struct packed {
        logic do_push;
        logic do_pop;
        logic drop;
    } fifo_op_t;

    function automatic fifo_op_t decode_op(
        input logic run,
        input logic en,
        input logic push,
        input logic pop,
        input logic full,
        input logic empty
    );
        fifo_op_t op;
        op.do_pop  = run & en & pop & ~empty;
        op.do_push = run & en & push & (~full | op.do_pop);
        op.drop    = run & en & push & full & ~op.do_pop;
        return op;
    endfunction

endpackage

// File: rtl/serfifo_store.sv
module serfifo_store
    import serfifo_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5,
    parameter int ADDR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  fifo_op_t         op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count
);

    localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(DEPTH - 1);

    logic [WIDTH-1:0]  slots [DEPTH];
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;

    function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (op.do_push) begin
            slots[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rdata  <= '0;
        end else if (!run) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (op.do_push) begin
                wr_ptr <= advance(wr_ptr);
            end
            if (op.do_pop) begin
                rd_ptr <= advance(rd_ptr);
                rdata  <= slots[rd_ptr];
            end
            count <= count + CNT_W'(op.do_push) - CNT_W'(op.do_pop);
        end
    end

endmodule

// File: rtl/serfifo_thresh.sv
module serfifo_thresh
    import serfifo_pkg::*;
#(
    parameter int        CNT_W = 5,
    parameter fifo_dir_e DIR   = DIR_RX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             level_wr,
    input  logic [CNT_W-1:0] level_in,
    input  logic [CNT_W-1:0] count,
    input  logic             clr,
    output logic [CNT_W-1:0] level,
    output logic             flag
);

    logic hit;

    generate
        if (DIR == DIR_RX) begin : g_rx
            assign hit = (count >= level);
        end else begin : g_tx
            assign hit = (count <= level);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '1;
        end else if (level_wr) begin
            level <= level_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (clr) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/serfifo_sticky.sv
module serfifo_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/serfifo_lvl.sv
module serfifo_lvl
    import serfifo_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter int        DEPTH = 16,
    parameter fifo_dir_e DIR   = DIR_RX,
    localparam int       CNT_W  = $clog2(DEPTH + 1),
    localparam int       ADDR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_run,
    input  logic             fifo_en,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CNT_W-1:0] fill_count,
    input  logic             level_wr,
    input  logic [CNT_W-1:0] level_in,
    output logic [CNT_W-1:0] level,
    input  logic             irq_en,
    input  logic             irq_clr,
    output logic             irq_flag,
    output logic             irq,
    input  logic             ovf_clr,
    output logic             ovf_flag
);

    fifo_op_t op;
    logic     full;
    logic     empty;

    assign full  = (fill_count == CNT_W'(DEPTH));
    assign empty = (fill_count == '0);
    assign op    = decode_op(fifo_run, fifo_en, push, pop, full, empty);

    serfifo_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .run  (fifo_run),
        .op   (op),
        .wdata(push_data),
        .rdata(pop_data),
        .count(fill_count)
    );

    serfifo_thresh #(
        .CNT_W(CNT_W),
        .DIR  (DIR)
    ) u_thresh (
        .clk     (clk),
        .rst     (rst),
        .level_wr(level_wr),
        .level_in(level_in),
        .count   (fill_count),
        .clr     (irq_clr),
        .level   (level),
        .flag    (irq_flag)
    );

    serfifo_sticky u_ovf (
        .clk(clk),
        .rst(rst),
        .set(op.drop),
        .clr(ovf_clr),
        .q  (ovf_flag)
    );

    assign irq = irq_flag & irq_en;

endmodule

// File: rtl/serfifo_lvl_chk.sv
module serfifo_lvl_chk
    import serfifo_pkg::*;
#(
    parameter int        WIDTH = 8,
    parameter int        DEPTH = 16,
    parameter fifo_dir_e DIR   = DIR_RX,
    parameter int        CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_run,
    input logic             fifo_en,
    input logic             push,
    input logic             pop,
    input logic [WIDTH-1:0] pop_data,
    input logic [CNT_W-1:0] fill_count,
    input logic [CNT_W-1:0] level,
    input logic             irq_en,
    input logic             irq_clr,
    input logic             irq_flag,
    input logic             irq,
    input logic             ovf_clr,
    input logic             ovf_flag
);

    logic full_c;
    logic lost;
    assign full_c = (fill_count == CNT_W'(DEPTH));
    assign lost   = fifo_run && fifo_en && push && !pop && full_c;

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        int'(fill_count) <= DEPTH);

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_run |=> (int'(fill_count) <= int'($past(fill_count)) + 1) &&
                     (int'(fill_count) + 1 >= int'($past(fill_count))));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        lost |=> ovf_flag && full_c);

    p_ovf_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !lost) |=> !ovf_flag);

    p_empty_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (fifo_run && fifo_en && pop && !push && fill_count == '0)
            |=> $stable(pop_data) && fill_count == '0);

    p_run_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !fifo_run |=> fill_count == '0);

    p_en_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (fifo_run && !fifo_en) |=> $stable(fill_count) && $stable(pop_data));

    p_irq_clear_r11: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> !irq_flag);

    p_irq_gate_r12: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    generate
        if (DIR == DIR_RX) begin : g_rx
            p_rx_set_r9: assert property (@(posedge clk) disable iff (rst)
                (!irq_clr && fill_count >= level) |=> irq_flag);
        end else begin : g_tx
            p_tx_set_r10: assert property (@(posedge clk) disable iff (rst)
                (!irq_clr && fill_count <= level) |=> irq_flag);
        end
    endgenerate

endmodule

bind serfifo_lvl serfifo_lvl_chk #(
    .WIDTH(WIDTH),
    .DEPTH(DEPTH),
    .DIR  (DIR),
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fifo_run  (fifo_run),
    .fifo_en   (fifo_en),
    .push      (push),
    .pop       (pop),
    .pop_data  (pop_data),
    .fill_count(fill_count),
    .level     (level),
    .irq_en    (irq_en),
    .irq_clr   (irq_clr),
    .irq_flag  (irq_flag),
    .irq       (irq),
    .ovf_clr   (ovf_clr),
    .ovf_flag  (ovf_flag)
);

// File: tb/serfifo_lvl_test.sv
module serfifo_lvl_test;
    import serfifo_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_run = 1'b1, fifo_en = 1'b1;
    logic       push = 1'b0, pop = 1'b0;
    logic [7:0] push_data = '0;
    logic       level_wr = 1'b0;
    logic [4:0] level_in = '0;
    logic       irq_en = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;

    logic [7:0] rx_pd, tx_pd;
    logic [4:0] rx_cnt, tx_cnt, rx_lvl, tx_lvl;
    logic       rx_flag, tx_flag, rx_irq, tx_irq, rx_ovf, tx_ovf;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [$];

    always #5 clk = ~clk;

    serfifo_lvl #(.DIR(DIR_RX)) uut (
        .clk(clk), .rst(rst), .fifo_run(fifo_run), .fifo_en(fifo_en),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(rx_pd),
        .fill_count(rx_cnt), .level_wr(level_wr), .level_in(level_in),
        .level(rx_lvl), .irq_en(irq_en), .irq_clr(irq_clr),
        .irq_flag(rx_flag), .irq(rx_irq), .ovf_clr(ovf_clr), .ovf_flag(rx_ovf));

    serfifo_lvl #(.DIR(DIR_TX)) uut_tx (
        .clk(clk), .rst(rst), .fifo_run(fifo_run), .fifo_en(fifo_en),
        .push(push), .push_data(push_data), .pop(pop), .pop_data(tx_pd),
        .fill_count(tx_cnt), .level_wr(level_wr), .level_in(level_in),
        .level(tx_lvl), .irq_en(irq_en), .irq_clr(irq_clr),
        .irq_flag(tx_flag), .irq(tx_irq), .ovf_clr(ovf_clr), .ovf_flag(tx_ovf));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    task automatic restart();
        fifo_run = 1'b0; tick(); fifo_run = 1'b1;
        model.delete();
    endtask

    task automatic do_push(input logic [7:0] d);
        push = 1'b1; push_data = d; tick(); push = 1'b0;
        if (model.size() < 16) model.push_back(d);
    endtask

    initial begin
        #2_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R1: reset state
        chk(rx_cnt == 0 && tx_cnt == 0, "R1 count", int'(rx_cnt), 0);
        chk(rx_lvl == 5'd31 && tx_lvl == 5'd31, "R1 level", int'(rx_lvl), 31);
        chk(rx_pd == 0 && !rx_flag && !rx_ovf && !rx_irq, "R1 flags", int'(rx_flag), 0);
        // R13: all-ones level keeps empty receive queue quiet
        irq_en = 1'b1;
        repeat (4) tick();
        chk(!rx_flag && !rx_irq, "R13 rx quiet", int'(rx_flag), 0);
        chk(tx_flag, "R10 tx empty below level", int'(tx_flag), 1);

        // R3/R4/R5: fill, overflow, clear
        for (int i = 0; i < 16; i++) begin
            do_push(pat(i));
            chk(rx_cnt == 5'(i + 1), "R3 count up", int'(rx_cnt), i + 1);
        end
        do_push(8'hEE);
        chk(rx_cnt == 16 && rx_ovf, "R4 drop on full", int'(rx_ovf), 1);
        repeat (3) tick();
        chk(rx_ovf, "R5 sticky", int'(rx_ovf), 1);
        ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
        chk(!rx_ovf && !tx_ovf, "R5 cleared", int'(rx_ovf), 0);
        // R4: push with pop at full is accepted
        push = 1'b1; pop = 1'b1; push_data = 8'hA5; tick(); push = 1'b0; pop = 1'b0;
        void'(model.pop_front()); model.push_back(8'hA5);
        chk(rx_cnt == 16 && !rx_ovf, "R4 swap at full", int'(rx_cnt), 16);

        // R2: drain in order
        for (int i = 0; i < 16; i++) begin
            logic [7:0] e;
            e = model.pop_front();
            pop = 1'b1; tick(); pop = 1'b0;
            chk(rx_pd == e, "R2 order", int'(rx_pd), int'(e));
            chk(rx_cnt == 5'(15 - i), "R3 count down", int'(rx_cnt), 15 - i);
        end
        // R6: empty pop
        pop = 1'b1; tick(); pop = 1'b0;
        chk(rx_pd == 8'hA5 && rx_cnt == 0, "R6 empty pop", int'(rx_pd), 'hA5);

        // R3: simultaneous push/pop mid-fill
        do_push(8'h11); do_push(8'h22);
        push = 1'b1; pop = 1'b1; push_data = 8'h33; tick(); push = 1'b0; pop = 1'b0;
        chk(rx_cnt == 2 && rx_pd == 8'h11, "R3 push+pop", int'(rx_cnt), 2);

        // R8: enable low freezes
        fifo_en = 1'b0;
        push = 1'b1; pop = 1'b1; push_data = 8'h44; repeat (3) tick();
        push = 1'b0; pop = 1'b0;
        chk(rx_cnt == 2 && rx_pd == 8'h11, "R8 frozen", int'(rx_cnt), 2);
        fifo_en = 1'b1;
        pop = 1'b1; tick(); pop = 1'b0;
        chk(rx_pd == 8'h22, "R8 contents kept", int'(rx_pd), 'h22);

        // R7: run low clears and ignores, level kept
        level_in = 5'd7; level_wr = 1'b1; tick(); level_wr = 1'b0;
        fifo_run = 1'b0; push = 1'b1; push_data = 8'h55; repeat (2) tick();
        push = 1'b0;
        chk(rx_cnt == 0, "R7 held empty", int'(rx_cnt), 0);
        chk(rx_lvl == 7 && tx_lvl == 7, "R7 level kept", int'(rx_lvl), 7);
        fifo_run = 1'b1; tick();
        chk(rx_cnt == 0, "R7 push ignored", int'(rx_cnt), 0);

        // R9/R10/R12/R13: sweep level x count
        for (int lv = 0; lv <= 16; lv++) begin
            for (int n = 0; n <= 16; n++) begin
                bit ex_rx, ex_tx;
                restart();
                irq_en = 1'(n & 1);
                level_in = 5'(lv); level_wr = 1'b1; tick(); level_wr = 1'b0;
                for (int k = 0; k < n; k++) do_push(pat(k + lv));
                irq_clr = 1'b1; tick(); irq_clr = 1'b0; tick();
                ex_rx = (n >= lv);
                ex_tx = (n <= lv);
                chk(rx_flag == ex_rx, "R9 rx compare", int'(rx_flag), int'(ex_rx));
                chk(tx_flag == ex_tx, "R10 tx compare", int'(tx_flag), int'(ex_tx));
                chk(rx_irq == (ex_rx & irq_en), "R12 gate", int'(rx_irq), int'(ex_rx & irq_en));
            end
        end

        // R11: clear then re-set while compare holds (rx: count 16 >= level 5)
        level_in = 5'd5; level_wr = 1'b1; tick(); level_wr = 1'b0; tick();
        chk(rx_flag, "R11 set", int'(rx_flag), 1);
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        chk(!rx_flag, "R11 cleared", int'(rx_flag), 0);
        tick();
        chk(rx_flag, "R11 re-set", int'(rx_flag), 1);
        // R11: flag sticks after compare stops holding
        level_in = 5'd31; level_wr = 1'b1; tick(); level_wr = 1'b0; repeat (2) tick();
        chk(rx_flag, "R11 sticky", int'(rx_flag), 1);
        // R13: level above 16 never met
        irq_clr = 1'b1; tick(); irq_clr = 1'b0; repeat (3) tick();
        chk(!rx_flag && rx_cnt == 16, "R13 level 31", int'(rx_flag), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule